// File: doc/BRIEF.md
# BCD Time-of-Day Minute Counter

This block keeps the time of day as hours and minutes in four binary-coded decimal digits. Each cycle in which the advance input is high moves the time forward by exactly one minute. It has two modes. In 24-hour mode the time runs from 00:00 to 23:59 and then wraps. In 12-hour mode it runs from 00:00 to 11:59, wraps, and flips a half-day flag each time it wraps.

The sixteen digit bits and the half-day flag all come from one register stage. Every transition, including each carry and each wrap, therefore appears on the outputs exactly one cycle after the advance that caused it. All bits change on the same edge. A one-cycle strobe marks that cycle.

The outgoing stream has no back-pressure. The strobe is a pulse and the value is held until the next advance, so a consumer must either take the bus when the strobe is high or sample it at leisure between advances. The mode input is sampled only while reset is asserted.

Top module: `tod_minute_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the time becomes 00:00, `pm` becomes 0, `valid` becomes 0, and `mode_12h` is captured as the operating mode (1 = 12-hour, 0 = 24-hour).
- R2: Every digit always stays in range. Minute ones is 0..9, minute tens is 0..5, and the hour is 00..23 in 24-hour mode or 00..11 in 12-hour mode.
- R3: An advance adds one minute. Minute ones wraps from 9 to 0 and carries into minute tens. Minute tens wraps from 5 to 0 and carries into the hours. Hour ones wraps from 9 to 0 and carries into hour tens.
- R4: In 24-hour mode, an advance at 23:59 gives 00:00, and `pm` stays 0 at all times.
- R5: In 12-hour mode, an advance at 11:59 gives 00:00 and inverts `pm`. No other advance changes `pm`.
- R6: In a cycle without an advance, `time_bcd` and `pm` keep their values.
- R7: When `adv` is high at edge k, the new time and `pm` appear on all outputs right after edge k, all on that one edge. `valid` is high for exactly the cycle after each edge at which `adv` was high, and low otherwise.
- R8: Changes on `mode_12h` while `rst` is low have no effect on counting.
- R9: `time_bcd` is packed as hour tens [15:12], hour ones [11:8], minute tens [7:4], minute ones [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Advance by one minute when high at an edge |
| mode_12h | input | 1 | Mode select, sampled in reset: 1 = 12-hour, 0 = 24-hour |
| time_bcd | output | 16 | Four packed BCD digits of the current time |
| pm | output | 1 | Half-day flag, 12-hour mode only |
| valid | output | 1 | One-cycle strobe with each updated value |

## Verification
The assertions assume that reset is held for at least one edge before counting begins, so that the state and the captured mode are known. They also assume that `adv` is a clean level sampled at rising edges.

The bench applies a reset at time zero and changes `adv` and `mode_12h` only on falling edges. It walks both modes through complete days and also drives random advance gaps. It toggles the mode line at random outside reset to confirm that counting ignores it.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DIGIT_W    = 4;
  localparam int MIN_DIGITS = 2;
  localparam int BUS_W      = 4 * DIGIT_W;

  typedef logic [DIGIT_W-1:0] bcd_t;

  typedef struct packed {
    bcd_t hr_t;
    bcd_t hr_o;
    bcd_t mn_t;
    bcd_t mn_o;
  } tod_t;

  // Highest value of each minute digit, index 0 = ones
  function automatic bcd_t min_limit(input int idx);
    return (idx == 0) ? bcd_t'(9) : bcd_t'(5);
  endfunction
endpackage

// File: rtl/tod_digit_stage.sv
module tod_digit_stage #(
  parameter int W = 4,
  parameter logic [W-1:0] LIMIT = 9
) (
  input  logic [W-1:0] cur,
  input  logic         inc,
  output logic [W-1:0] nxt,
  output logic         carry
);
  logic at_top;
  assign at_top = (cur == LIMIT);
  assign carry  = inc && at_top;

  always_comb begin
    if (!inc)        nxt = cur;
    else if (at_top) nxt = '0;
    else             nxt = cur + W'(1);
  end
endmodule

// File: rtl/tod_hour_stage.sv
module tod_hour_stage #(
  parameter int W = 4
) (
  input  logic [W-1:0] tens,
  input  logic [W-1:0] ones,
  input  logic         inc,
  input  logic         twelve,
  output logic [W-1:0] tens_n,
  output logic [W-1:0] ones_n,
  output logic         wrap
);
  logic last_hour;

  always_comb begin
    if (twelve) last_hour = (tens == W'(1)) && (ones == W'(1));
    else        last_hour = (tens == W'(2)) && (ones == W'(3));
  end

  assign wrap = inc && last_hour;

  always_comb begin
    tens_n = tens;
    ones_n = ones;
    if (inc) begin
      if (last_hour) begin
        tens_n = '0;
        ones_n = '0;
      end else if (ones == W'(9)) begin
        ones_n = '0;
        tens_n = tens + W'(1);
      end else begin
        ones_n = ones + W'(1);
      end
    end
  end
endmodule

// File: rtl/tod_minute_counter.sv
module tod_minute_counter
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             mode_12h,
  output logic [BUS_W-1:0] time_bcd,
  output logic             pm,
  output logic             valid
);
  tod_t cur_q;
  tod_t nxt;
  logic mode_q;
  logic pm_q;
  logic valid_q;
  logic hour_wrap;

  bcd_t min_cur [MIN_DIGITS];
  bcd_t min_nxt [MIN_DIGITS];
  logic [MIN_DIGITS:0] chain;

  assign min_cur[0] = cur_q.mn_o;
  assign min_cur[1] = cur_q.mn_t;
  assign chain[0]   = adv;

  for (genvar i = 0; i < MIN_DIGITS; i++) begin : g_min
    tod_digit_stage #(.W(DIGIT_W), .LIMIT(min_limit(i))) u_dig (
      .cur   (min_cur[i]),
      .inc   (chain[i]),
      .nxt   (min_nxt[i]),
      .carry (chain[i+1])
    );
  end

  tod_hour_stage #(.W(DIGIT_W)) u_hour (
    .tens   (cur_q.hr_t),
    .ones   (cur_q.hr_o),
    .inc    (chain[MIN_DIGITS]),
    .twelve (mode_q),
    .tens_n (nxt.hr_t),
    .ones_n (nxt.hr_o),
    .wrap   (hour_wrap)
  );

  assign nxt.mn_o = min_nxt[0];
  assign nxt.mn_t = min_nxt[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      pm_q    <= 1'b0;
      valid_q <= 1'b0;
      mode_q  <= mode_12h;
    end else begin
      valid_q <= adv;
      if (adv) begin
        cur_q <= nxt;
        if (hour_wrap && mode_q) pm_q <= ~pm_q;
      end
    end
  end

  assign time_bcd = cur_q;
  assign pm       = pm_q;
  assign valid    = valid_q;
endmodule

// File: rtl/tod_checker.sv
module tod_checker (
  input logic        clk,
  input logic        rst,
  input logic        adv,
  input logic        mode_q,
  input logic [15:0] time_bcd,
  input logic        pm,
  input logic        valid
);
  logic [3:0] ht, ho, mt, mo;
  assign ht = time_bcd[15:12];
  assign ho = time_bcd[11:8];
  assign mt = time_bcd[7:4];
  assign mo = time_bcd[3:0];

  a_r2_digit_range: assert property (@(posedge clk) disable iff (rst)
    (mo <= 4'd9) && (mt <= 4'd5) &&
    (mode_q ? (ht == 4'd0 && ho <= 4'd9) || (ht == 4'd1 && ho <= 4'd1)
            : (ht <= 4'd1 && ho <= 4'd9) || (ht == 4'd2 && ho <= 4'd3)));

  a_r3_ones_step: assert property (@(posedge clk) disable iff (rst)
    (adv && mo != 4'd9) |=> (mo == $past(mo) + 4'd1) && $stable(time_bcd[15:4]));

  a_r4_wrap_day: assert property (@(posedge clk) disable iff (rst)
    (adv && !mode_q && time_bcd == 16'h2359) |=> (time_bcd == 16'h0000));

  a_r4_pm_low: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> !pm);

  a_r5_half_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && mode_q && time_bcd == 16'h1159) |=> (time_bcd == 16'h0000) && (pm != $past(pm)));

  a_r5_pm_hold: assert property (@(posedge clk) disable iff (rst)
    !(adv && time_bcd == 16'h1159) |=> $stable(pm));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(time_bcd) && $stable(pm));

  a_r7_strobe_hi: assert property (@(posedge clk) disable iff (rst)
    adv |=> valid);

  a_r7_strobe_lo: assert property (@(posedge clk) disable iff (rst)
    !adv |=> !valid);

  a_r8_mode_fixed: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));
endmodule

bind tod_minute_counter tod_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .adv      (adv),
  .mode_q   (mode_q),
  .time_bcd (time_bcd),
  .pm       (pm),
  .valid    (valid)
);

// File: tb/sim_tod_minute_counter.sv
module sim_tod_minute_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv = 1'b0;
  logic        mode_12h = 1'b0;
  logic [15:0] time_bcd;
  logic        pm;
  logic        valid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int ref_h, ref_m;
  bit ref_pm, ref_twelve;

  always #2 clk = ~clk;

  tod_minute_counter u0 (
    .clk(clk), .rst(rst), .adv(adv), .mode_12h(mode_12h),
    .time_bcd(time_bcd), .pm(pm), .valid(valid)
  );

  // R9 packing: hour tens, hour ones, minute tens, minute ones
  function automatic logic [15:0] pack(input int h, input int m);
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10)};
  endfunction

  function automatic bit bcd_ok(input logic [15:0] v);
    return v[3:0] <= 9 && v[7:4] <= 5 && v[11:8] <= 9 && v[15:12] <= 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    ref_m++;
    if (ref_m == 60) begin
      ref_m = 0;
      ref_h++;
      if (ref_h == (ref_twelve ? 12 : 24)) begin
        ref_h = 0;
        if (ref_twelve) ref_pm = ~ref_pm;
      end
    end
  endtask

  task automatic do_reset(input bit twelve);
    @(negedge clk);
    rst = 1'b1; adv = 1'b0; mode_12h = twelve;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
    mode_12h = ~twelve;    // R8: flipping the mode after reset must be ignored
    ref_h = 0; ref_m = 0; ref_pm = 0; ref_twelve = twelve;
    chk(time_bcd == 16'h0000, "R1 time", time_bcd, 0);
    chk(pm == 1'b0, "R1 pm", pm, 0);
    chk(valid == 1'b0, "R1 valid", valid, 0);
  endtask

  // Drive on the falling edge; the result is visible right after the next rising edge (R7)
  task automatic step(input bit a, input bit flip_mode);
    @(negedge clk);
    adv = a;
    if (flip_mode) mode_12h = ~mode_12h;
    @(posedge clk); #1;
    if (a) model_step();
    chk(time_bcd == pack(ref_h, ref_m), a ? "R3 time" : "R6 time", time_bcd, pack(ref_h, ref_m));
    chk(pm == ref_pm, ref_twelve ? "R5 pm" : "R4 pm", pm, ref_pm);
    chk(valid == a, "R7 valid", valid, a);
    chk(bcd_ok(time_bcd), "R2 digits", time_bcd, 0);
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));

    // 24-hour mode: one full day, then the wrap
    do_reset(1'b0);
    for (int i = 0; i < 1439; i++) step(1'b1, 1'b0);
    chk(time_bcd == 16'h2359, "R4 last", time_bcd, 16'h2359);
    step(1'b1, 1'b0);
    chk(time_bcd == 16'h0000, "R4 wrap", time_bcd, 0);
    step(1'b0, 1'b0);
    chk(time_bcd == 16'h0000, "R6 idle", time_bcd, 0);

    // Random advances with gaps and mode-line noise (R6, R8)
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, ($urandom % 16) == 0);

    // 12-hour mode: two half days
    do_reset(1'b1);
    for (int i = 0; i < 719; i++) step(1'b1, ($urandom % 32) == 0);
    chk(time_bcd == 16'h1159 && pm == 0, "R5 last", time_bcd, 16'h1159);
    step(1'b1, 1'b0);
    chk(time_bcd == 16'h0000 && pm == 1, "R5 toggle", {pm, time_bcd}, 17'h10000);
    for (int i = 0; i < 720; i++) step(1'b1, 1'b0);
    chk(time_bcd == 16'h0000 && pm == 0, "R5 back", {pm, time_bcd}, 0);

    for (int i = 0; i < 2000; i++)
      step(($urandom % 3) != 0, ($urandom % 16) == 0);

    // Directed R9 and R3 carry: 09:59 -> 10:00 in 24-hour mode
    do_reset(1'b0);
    for (int i = 0; i < 599; i++) step(1'b1, 1'b0);
    chk(time_bcd == 16'h0959, "R9 pack", time_bcd, 16'h0959);
    step(1'b1, 1'b0);
    chk(time_bcd == 16'h1000, "R3 carry", time_bcd, 16'h1000);

    // Reset in mid count (R1)
    do_reset(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule